// File: doc/BRIEF.md
# Pipeline Hazard Interlock Unit

This block sits at the issue stage of an in-order pipeline with a parameterised number of stages after issue. It keeps a record of every instruction that has been accepted and is still in flight. It compares the instruction that asks to issue against all of those records in the same cycle, looking for three kinds of register conflict:

- read-after-write (RAW): an older instruction writes a register that the new one reads;
- write-after-read (WAR): the new instruction writes a register that an older one still reads;
- write-after-write (WAW): both write the same register.

For each conflict the block decides whether issue must wait. A read-after-write conflict can often be resolved without waiting. Each source operand then gets a select code that names the pipeline stage holding the newest copy of the value. The datapath uses that code to forward the value.

Timing model:

- An accepted instruction enters stage 1 on the clock edge that accepts it.
- It moves forward one stage on every edge and leaves after stage `NUM_STAGES`.
- A stalled request is not accepted. A bubble enters stage 1 in its place.
- Each instruction states the stage in which its result is produced (its result stage). Its destination is written in that stage. The value can be forwarded from that stage and from every later stage.
- Each instruction also states the stage in which it consumes its sources (its read stage). A value of 0 means it reads them at issue.

Top module: `hazard_interlock`

## Requirements
- R1: After reset no instruction is in flight. With an idle issue port, all outputs are 0.
- R2: `haz_raw` is 1 when a valid in-flight destination equals a valid source of the issuing instruction.
- R3: `haz_war` is 1 when the valid destination of the issuing instruction equals a valid source of an in-flight instruction.
- R4: `haz_waw` is 1 when the valid destination of the issuing instruction equals a valid in-flight destination.
- R5: Register index 0 never causes a hazard. A field whose valid bit is 0 never causes a hazard.
- R6: For each source, only the youngest in-flight writer of that register is considered. If its current stage is at or past its result stage, the select for that source is its stage number and that source does not stall issue. If it is before its result stage, issue stalls and the select is 0. Select encoding: 0 means the register file, and k means pipeline stage k.
- R7: When several in-flight instructions write the same source register, the one in the lowest-numbered stage supplies the forwarding select.
- R8: A WAR conflict with a reader in stage s stalls issue when the issuing instruction's result stage plus s is at most the reader's read stage.
- R9: A WAW conflict with an older writer in stage s stalls issue when the issuing instruction's result stage plus s is at most the older writer's result stage.
- R10: A stalled request is not entered. Entries advance one stage per cycle and stop causing hazards once they have left stage `NUM_STAGES`.
- R11: `stall` and the three hazard flags are 0 whenever `iss_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An instruction requests issue |
| iss_src0_v | input | 1 | Source 0 is used |
| iss_src0 | input | REG_W | Source 0 register index |
| iss_src1_v | input | 1 | Source 1 is used |
| iss_src1 | input | REG_W | Source 1 register index |
| iss_dst_v | input | 1 | Destination is used |
| iss_dst | input | REG_W | Destination register index |
| iss_res_stg | input | STG_W | Stage in which the result is produced |
| iss_rd_stg | input | STG_W | Stage in which sources are consumed (0 means at issue) |
| stall | output | 1 | Hold the request; it is not accepted this cycle |
| haz_raw | output | 1 | A read-after-write conflict is present |
| haz_war | output | 1 | A write-after-read conflict is present |
| haz_waw | output | 1 | A write-after-write conflict is present |
| fwd_sel0 | output | STG_W | Forwarding select for source 0 |
| fwd_sel1 | output | STG_W | Forwarding select for source 1 |

## Verification
All hazard outputs are combinational from the in-flight record. A record that is lost, duplicated or shifted by one stage therefore shows up at the ports on the first request that names its register.

A wrong stage position has two visible effects:

- a forwarding select that is off by one;
- a stall that ends one cycle early or late at the result-stage and read-stage boundaries.

The bench probes each instruction at chosen distances after issue. Those distances include the exact equality cases of the stall rules and the cycle after an entry leaves the last stage.

// File: rtl/hzi_pkg.sv
package hzi_pkg;
  // Bit positions of the three conflict kinds in an internal summary vector.
  typedef enum int unsigned {
    HZ_RAW = 0,
    HZ_WAR = 1,
    HZ_WAW = 2
  } hz_kind_e;

  localparam int unsigned HZ_KINDS = 3;

  // Width needed to hold stage numbers 0..n.
  function automatic int unsigned stage_bits(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/hzi_slot_track.sv
module hzi_slot_track #(
  parameter int unsigned NUM_STAGES = 5,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned STG_W      = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               fire,
  input  logic                               in_s0v,
  input  logic [REG_W-1:0]                   in_s0,
  input  logic                               in_s1v,
  input  logic [REG_W-1:0]                   in_s1,
  input  logic                               in_dv,
  input  logic [REG_W-1:0]                   in_dst,
  input  logic [STG_W-1:0]                   in_res,
  input  logic [STG_W-1:0]                   in_rd,
  output logic [NUM_STAGES-1:0]              sl_vld,
  output logic [NUM_STAGES-1:0]              sl_s0v,
  output logic [NUM_STAGES-1:0][REG_W-1:0]   sl_s0,
  output logic [NUM_STAGES-1:0]              sl_s1v,
  output logic [NUM_STAGES-1:0][REG_W-1:0]   sl_s1,
  output logic [NUM_STAGES-1:0]              sl_dv,
  output logic [NUM_STAGES-1:0][REG_W-1:0]   sl_dst,
  output logic [NUM_STAGES-1:0][STG_W-1:0]   sl_res,
  output logic [NUM_STAGES-1:0][STG_W-1:0]   sl_rd
);
  // Slot k holds the instruction in pipeline stage k+1.
  logic [NUM_STAGES-1:0] vld_nxt;
  logic [NUM_STAGES-1:0] ld_en;

  always_comb begin
    vld_nxt = {sl_vld[NUM_STAGES-2:0], fire};
    ld_en   = {sl_vld[NUM_STAGES-2:0], fire};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_vld <= '0;
    end else begin
      sl_vld <= vld_nxt;
    end
  end

  // Payload registers: loaded only when a live entry moves in.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sl_s0v <= '0;
      sl_s0  <= '0;
      sl_s1v <= '0;
      sl_s1  <= '0;
      sl_dv  <= '0;
      sl_dst <= '0;
      sl_res <= '0;
      sl_rd  <= '0;
    end else begin
      if (ld_en[0]) begin
        sl_s0v[0] <= in_s0v;
        sl_s0[0]  <= in_s0;
        sl_s1v[0] <= in_s1v;
        sl_s1[0]  <= in_s1;
        sl_dv[0]  <= in_dv;
        sl_dst[0] <= in_dst;
        sl_res[0] <= in_res;
        sl_rd[0]  <= in_rd;
      end
      for (int k = 1; k < NUM_STAGES; k++) begin
        if (ld_en[k]) begin
          sl_s0v[k] <= sl_s0v[k-1];
          sl_s0[k]  <= sl_s0[k-1];
          sl_s1v[k] <= sl_s1v[k-1];
          sl_s1[k]  <= sl_s1[k-1];
          sl_dv[k]  <= sl_dv[k-1];
          sl_dst[k] <= sl_dst[k-1];
          sl_res[k] <= sl_res[k-1];
          sl_rd[k]  <= sl_rd[k-1];
        end
      end
    end
  end
endmodule

// File: rtl/hzi_slot_cmp.sv
module hzi_slot_cmp #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned STG_W = 3,
  parameter int unsigned STAGE = 1
) (
  input  logic             sl_vld,
  input  logic             sl_s0v,
  input  logic [REG_W-1:0] sl_s0,
  input  logic             sl_s1v,
  input  logic [REG_W-1:0] sl_s1,
  input  logic             sl_dv,
  input  logic [REG_W-1:0] sl_dst,
  input  logic [STG_W-1:0] sl_res,
  input  logic [STG_W-1:0] sl_rd,
  input  logic             nw_s0v,
  input  logic [REG_W-1:0] nw_s0,
  input  logic             nw_s1v,
  input  logic [REG_W-1:0] nw_s1,
  input  logic             nw_dv,
  input  logic [REG_W-1:0] nw_dst,
  input  logic [STG_W-1:0] nw_res,
  output logic             raw0,
  output logic             raw1,
  output logic             avail,
  output logic             war_hit,
  output logic             war_stl,
  output logic             waw_hit,
  output logic             waw_stl
);
  localparam logic [STG_W:0] STG_C = STAGE[STG_W:0];

  logic            sl_writes;
  logic            nw_writes;
  logic            rd0_live;
  logic            rd1_live;
  logic [STG_W:0]  nw_done;

  always_comb begin
    sl_writes = sl_vld && sl_dv && (sl_dst != '0);
    nw_writes = nw_dv && (nw_dst != '0);
    rd0_live  = sl_vld && sl_s0v && (sl_s0 != '0);
    rd1_live  = sl_vld && sl_s1v && (sl_s1 != '0);

    raw0 = sl_writes && nw_s0v && (nw_s0 == sl_dst);
    raw1 = sl_writes && nw_s1v && (nw_s1 == sl_dst);
    avail = STG_C >= {1'b0, sl_res};

    // Relative time at which the new instruction writes, seen from this slot.
    nw_done = {1'b0, nw_res} + STG_C;

    war_hit = nw_writes &&
              ((rd0_live && (sl_s0 == nw_dst)) || (rd1_live && (sl_s1 == nw_dst)));
    war_stl = war_hit && (nw_done <= {1'b0, sl_rd});

    waw_hit = nw_writes && sl_writes && (sl_dst == nw_dst);
    waw_stl = waw_hit && (nw_done <= {1'b0, sl_res});
  end
endmodule

// File: rtl/hzi_fwd_pick.sv
module hzi_fwd_pick #(
  parameter int unsigned NUM_STAGES = 5,
  parameter int unsigned STG_W      = 3
) (
  input  logic [NUM_STAGES-1:0] hit,
  input  logic [NUM_STAGES-1:0] avail,
  output logic [STG_W-1:0]      sel,
  output logic                  wait_req
);
  // Scan oldest to youngest so the lowest slot index is the last to set the result.
  always_comb begin
    sel      = '0;
    wait_req = 1'b0;
    for (int k = NUM_STAGES - 1; k >= 0; k--) begin
      if (hit[k]) begin
        sel      = avail[k] ? STG_W'(k + 1) : '0;
        wait_req = !avail[k];
      end
    end
  end
endmodule

// File: rtl/hazard_interlock.sv
module hazard_interlock #(
  parameter int unsigned NUM_STAGES = 5,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned STG_W      = hzi_pkg::stage_bits(NUM_STAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic             iss_src0_v,
  input  logic [REG_W-1:0] iss_src0,
  input  logic             iss_src1_v,
  input  logic [REG_W-1:0] iss_src1,
  input  logic             iss_dst_v,
  input  logic [REG_W-1:0] iss_dst,
  input  logic [STG_W-1:0] iss_res_stg,
  input  logic [STG_W-1:0] iss_rd_stg,
  output logic             stall,
  output logic             haz_raw,
  output logic             haz_war,
  output logic             haz_waw,
  output logic [STG_W-1:0] fwd_sel0,
  output logic [STG_W-1:0] fwd_sel1
);
  import hzi_pkg::*;

  logic [NUM_STAGES-1:0]            sl_vld, sl_s0v, sl_s1v, sl_dv;
  logic [NUM_STAGES-1:0][REG_W-1:0] sl_s0, sl_s1, sl_dst;
  logic [NUM_STAGES-1:0][STG_W-1:0] sl_res, sl_rd;

  logic [NUM_STAGES-1:0] raw0_v, raw1_v, avail_v;
  logic [NUM_STAGES-1:0] war_hit_v, war_stl_v, waw_hit_v, waw_stl_v;

  logic             nw_s0v, nw_s1v, nw_dv;
  logic             wait0, wait1;
  logic [STG_W-1:0] sel0, sel1;
  logic [HZ_KINDS-1:0] kind;
  logic             fire;

  // Requests are qualified once so every comparator sees an idle port as empty.
  always_comb begin
    nw_s0v = iss_valid && iss_src0_v && (iss_src0 != '0);
    nw_s1v = iss_valid && iss_src1_v && (iss_src1 != '0);
    nw_dv  = iss_valid && iss_dst_v;
  end

  hzi_slot_track #(
    .NUM_STAGES(NUM_STAGES), .REG_W(REG_W), .STG_W(STG_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .in_s0v(iss_src0_v), .in_s0(iss_src0),
    .in_s1v(iss_src1_v), .in_s1(iss_src1),
    .in_dv(iss_dst_v), .in_dst(iss_dst),
    .in_res(iss_res_stg), .in_rd(iss_rd_stg),
    .sl_vld(sl_vld), .sl_s0v(sl_s0v), .sl_s0(sl_s0),
    .sl_s1v(sl_s1v), .sl_s1(sl_s1), .sl_dv(sl_dv), .sl_dst(sl_dst),
    .sl_res(sl_res), .sl_rd(sl_rd)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_cmp
    hzi_slot_cmp #(
      .REG_W(REG_W), .STG_W(STG_W), .STAGE(g + 1)
    ) u_cmp (
      .sl_vld(sl_vld[g]), .sl_s0v(sl_s0v[g]), .sl_s0(sl_s0[g]),
      .sl_s1v(sl_s1v[g]), .sl_s1(sl_s1[g]), .sl_dv(sl_dv[g]),
      .sl_dst(sl_dst[g]), .sl_res(sl_res[g]), .sl_rd(sl_rd[g]),
      .nw_s0v(nw_s0v), .nw_s0(iss_src0), .nw_s1v(nw_s1v), .nw_s1(iss_src1),
      .nw_dv(nw_dv), .nw_dst(iss_dst), .nw_res(iss_res_stg),
      .raw0(raw0_v[g]), .raw1(raw1_v[g]), .avail(avail_v[g]),
      .war_hit(war_hit_v[g]), .war_stl(war_stl_v[g]),
      .waw_hit(waw_hit_v[g]), .waw_stl(waw_stl_v[g])
    );
  end

  hzi_fwd_pick #(.NUM_STAGES(NUM_STAGES), .STG_W(STG_W)) u_pick0 (
    .hit(raw0_v), .avail(avail_v), .sel(sel0), .wait_req(wait0)
  );

  hzi_fwd_pick #(.NUM_STAGES(NUM_STAGES), .STG_W(STG_W)) u_pick1 (
    .hit(raw1_v), .avail(avail_v), .sel(sel1), .wait_req(wait1)
  );

  always_comb begin
    kind         = '0;
    kind[HZ_RAW] = |{raw0_v, raw1_v};
    kind[HZ_WAR] = |war_hit_v;
    kind[HZ_WAW] = |waw_hit_v;

    haz_raw  = kind[HZ_RAW];
    haz_war  = kind[HZ_WAR];
    haz_waw  = kind[HZ_WAW];
    stall    = iss_valid && (wait0 || wait1 || (|war_stl_v) || (|waw_stl_v));
    fire     = iss_valid && !stall;
    fwd_sel0 = sel0;
    fwd_sel1 = sel1;
  end
endmodule

// File: rtl/hzi_checker.sv
module hzi_checker #(
  parameter int unsigned NUM_STAGES = 5,
  parameter int unsigned REG_W      = 5,
  parameter int unsigned STG_W      = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_src0_v,
  input logic [REG_W-1:0] iss_src0,
  input logic             iss_src1_v,
  input logic [REG_W-1:0] iss_src1,
  input logic             iss_dst_v,
  input logic [REG_W-1:0] iss_dst,
  input logic [STG_W-1:0] iss_res_stg,
  input logic             stall,
  input logic             haz_raw,
  input logic             haz_war,
  input logic             haz_waw,
  input logic [STG_W-1:0] fwd_sel0,
  input logic [STG_W-1:0] fwd_sel1
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !(stall || haz_raw || haz_war || haz_waw));

  // R8, R9: no stall without one of the three conflicts.
  assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (haz_raw || haz_war || haz_waw));

  assert_fwd_only_raw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((fwd_sel0 != '0) || (fwd_sel1 != '0)) |-> haz_raw);

  assert_fwd_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_sel0 <= STG_W'(NUM_STAGES)) && (fwd_sel1 <= STG_W'(NUM_STAGES)));

  assert_zero_reg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_src0 == '0 && iss_src1 == '0 && iss_dst == '0) |->
      !(haz_raw || haz_war || haz_waw));

  assert_youngest_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !stall && iss_dst_v && iss_dst != '0 && iss_res_stg <= STG_W'(1)) |=>
      (!(iss_valid && iss_src0_v && iss_src0 == $past(iss_dst)) || fwd_sel0 == STG_W'(1)));

  assert_young_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !stall && iss_dst_v && iss_dst != '0 && iss_res_stg > STG_W'(1)) |=>
      (!(iss_valid && iss_src0_v && iss_src0 == $past(iss_dst)) || stall));
endmodule

bind hazard_interlock hzi_checker #(
  .NUM_STAGES(NUM_STAGES), .REG_W(REG_W), .STG_W(STG_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
  .iss_src0_v(iss_src0_v), .iss_src0(iss_src0),
  .iss_src1_v(iss_src1_v), .iss_src1(iss_src1),
  .iss_dst_v(iss_dst_v), .iss_dst(iss_dst), .iss_res_stg(iss_res_stg),
  .stall(stall), .haz_raw(haz_raw), .haz_war(haz_war), .haz_waw(haz_waw),
  .fwd_sel0(fwd_sel0), .fwd_sel1(fwd_sel1)
);

// File: tb/tb_hazard_interlock.sv
module tb_hazard_interlock;
  localparam int unsigned NS = 5;
  localparam int unsigned RW = 5;
  localparam int unsigned SW = 3;

  typedef struct packed {
    logic          s0v;
    logic [RW-1:0] s0;
    logic          s1v;
    logic [RW-1:0] s1;
    logic          dv;
    logic [RW-1:0] d;
    logic [SW-1:0] res;
    logic [SW-1:0] rd;
  } ins_t;

  typedef struct packed {
    ins_t          p;
    logic [2:0]    gap;
    ins_t          q;
    logic          e_stall;
    logic          e_raw;
    logic          e_war;
    logic          e_waw;
    logic [SW-1:0] e_f0;
    logic [SW-1:0] e_f1;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 14;
  // Producer p issues into an empty pipeline; probe q is offered when p is in stage gap+1.
  localparam vec_t TBL [NV] = '{
    '{'{0,0,0,0,1,3,1,0}, 0, '{1,3,0,0,0,0,0,0}, 0,1,0,0, 1,0, 6},  // R2 R6 ready in stage 1
    '{'{0,0,0,0,1,3,3,0}, 0, '{1,3,0,0,0,0,0,0}, 1,1,0,0, 0,0, 6},  // R6 not ready
    '{'{0,0,0,0,1,3,3,0}, 2, '{0,0,1,3,0,0,0,0}, 0,1,0,0, 0,3, 6},  // R6 ready in stage 3
    '{'{0,0,0,0,1,0,1,0}, 0, '{1,0,0,0,0,0,0,0}, 0,0,0,0, 0,0, 5},  // R5 register 0
    '{'{0,0,0,0,0,4,1,0}, 0, '{1,4,0,0,0,0,0,0}, 0,0,0,0, 0,0, 5},  // R5 invalid dest
    '{'{1,6,0,0,0,0,0,0}, 0, '{0,0,0,0,1,6,1,0}, 0,0,1,0, 0,0, 3},  // R3 early reader
    '{'{1,6,0,0,0,0,0,4}, 0, '{0,0,0,0,1,6,2,0}, 1,0,1,0, 0,0, 8},  // R8 2+1<=4
    '{'{0,0,1,6,0,0,0,4}, 1, '{0,0,0,0,1,6,2,0}, 1,0,1,0, 0,0, 8},  // R8 2+2<=4 equality
    '{'{0,0,1,6,0,0,0,4}, 2, '{0,0,0,0,1,6,2,0}, 0,0,1,0, 0,0, 8},  // R8 2+3>4
    '{'{0,0,0,0,1,7,4,0}, 0, '{0,0,0,0,1,7,2,0}, 1,0,0,1, 0,0, 9},  // R4 R9 stall
    '{'{0,0,0,0,1,7,4,0}, 1, '{0,0,0,0,1,7,3,0}, 0,0,0,1, 0,0, 9},  // R9 3+2>4
    '{'{0,0,0,0,1,8,1,0}, 5, '{1,8,0,0,0,0,0,0}, 0,0,0,0, 0,0,10},  // R10 retired
    '{'{0,0,0,0,1,8,1,0}, 4, '{1,8,0,0,0,0,0,0}, 0,1,0,0, 5,0,10},  // R10 last stage
    '{'{1,10,0,0,1,9,1,3},0, '{1,9,1,9,1,10,1,0},1,1,1,0, 1,1, 8}   // R8 combined
  };

  logic          clk, rst_n;
  logic          iss_valid;
  ins_t          cur;
  logic          stall, haz_raw, haz_war, haz_waw;
  logic [SW-1:0] fwd_sel0, fwd_sel1;
  int            n_run, n_fail;
  bit            done;

  hazard_interlock #(.NUM_STAGES(NS), .REG_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
    .iss_src0_v(cur.s0v), .iss_src0(cur.s0),
    .iss_src1_v(cur.s1v), .iss_src1(cur.s1),
    .iss_dst_v(cur.dv), .iss_dst(cur.d),
    .iss_res_stg(cur.res), .iss_rd_stg(cur.rd),
    .stall(stall), .haz_raw(haz_raw), .haz_war(haz_war), .haz_waw(haz_waw),
    .fwd_sel0(fwd_sel0), .fwd_sel1(fwd_sel1)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic es, input logic er,
                         input logic ew, input logic ea, input int f0, input int f1);
    chk({tag, " stall"}, stall, es);
    chk({tag, " raw"},   haz_raw, er);
    chk({tag, " war"},   haz_war, ew);
    chk({tag, " waw"},   haz_waw, ea);
    chk({tag, " sel0"},  fwd_sel0, f0);
    chk({tag, " sel1"},  fwd_sel1, f1);
  endtask

  task automatic flush();
    iss_valid = 1'b0;
    cur = '0;
    repeat (NS + 2) @(negedge clk);
  endtask

  task automatic give(input ins_t i);
    cur = i;
    iss_valid = 1'b1;
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; iss_valid = 1'b0; cur = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk_all("R1 reset idle", 0, 0, 0, 0, 0, 0);
    give('{1,3,1,4,1,5,1,0}); #1;
    chk_all("R1 reset probe", 0, 0, 0, 0, 0, 0);
    flush();

    for (int v = 0; v < NV; v++) begin
      give(TBL[v].p);
      @(negedge clk);
      iss_valid = 1'b0;
      repeat (int'(TBL[v].gap)) @(negedge clk);
      give(TBL[v].q); #1;
      chk_all($sformatf("R%0d vec%0d", TBL[v].req, v), TBL[v].e_stall, TBL[v].e_raw,
              TBL[v].e_war, TBL[v].e_waw, int'(TBL[v].e_f0), int'(TBL[v].e_f1));
      flush();
    end

    // R11: matching in-flight writer but the port is idle.
    give('{0,0,0,0,1,3,3,0});
    @(negedge clk);
    cur = '{1,3,0,0,1,3,1,0}; iss_valid = 1'b0; #1;
    chk_all("R11 idle", 0, 0, 0, 0, 0, 0);
    flush();

    // R7: two ready writers of r5; the younger one in stage 1 wins.
    give('{0,0,0,0,1,5,1,0}); @(negedge clk);
    give('{0,0,0,0,1,5,1,0}); @(negedge clk);
    give('{1,5,0,0,0,0,0,0}); #1;
    chk("R7 youngest sel", fwd_sel0, 1);
    chk("R7 youngest nostall", stall, 0);
    flush();

    // R7: the younger writer is not ready, so issue waits even though the older one is.
    give('{0,0,0,0,1,5,1,0}); @(negedge clk);
    give('{0,0,0,0,1,5,3,0}); @(negedge clk);
    give('{0,0,1,5,0,0,0,0}); #1;
    chk("R7 young wait stall", stall, 1);
    chk("R7 young wait sel", fwd_sel1, 0);
    flush();

    // R10: a held request stalls in stages 1 and 2 of the producer, then issues;
    // it enters exactly once, in stage 1.
    give('{0,0,0,0,1,3,3,0}); @(negedge clk);
    give('{1,3,0,0,1,11,1,0}); #1;
    chk("R10 hold c1", stall, 1);
    @(negedge clk); #1;
    chk("R10 hold c2", stall, 1);
    @(negedge clk); #1;
    chk("R10 release", stall, 0);
    chk("R10 release sel", fwd_sel0, 3);
    @(negedge clk);
    give('{1,11,0,0,0,0,0,0}); #1;
    chk("R10 entered once", fwd_sel0, 1);
    chk("R10 entered nostall", stall, 0);
    flush();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule